// File: doc/BRIEF.md
# Transparent Bridge Address Decoder

This block makes the claim decision for a transparent bridge that sits between an upstream (primary) bus and a downstream (secondary) bus. For every request it receives the 64-bit address, a command code, the side of the bridge the request was seen on, and the window settings held in an outside register file. It reports whether the bridge accepts the request and in which direction to pass it on. The result appears one clock after the request.

The secondary bus owns three programmable windows: one for I/O, one for memory and one for prefetchable memory. A request on the primary side is accepted when its address falls inside a window of its own kind, and it then goes downstream. A request on the secondary side is accepted when its address is outside every window of its kind, and it then goes upstream. This is the inverse rule. An optional opaque window, when it is switched on, makes the bridge ignore memory requests on both sides. The address is passed on unchanged.

On the secondary side the only configuration traffic accepted is a Type 1 write that asks for conversion into a special cycle upstream.

Top module: `bridge_addr_decoder`

## Requirements
- R1: A primary-side request (`req_side`=0) with an I/O command (code 0 read, 1 write) is claimed when its address is in the I/O window. A primary-side memory command (code 2 read, 3 write) is claimed when its address is in the memory window or the prefetchable window. A claimed primary request reports `dec_dir`=0 (downstream).
- R2: A secondary-side request (`req_side`=1) with an I/O or memory command is claimed when its address lies outside every window of its kind. It then reports `dec_dir`=1 (upstream). If the address lies inside such a window, it is not claimed.
- R3: Windows are inclusive at both ends and compare at a fixed granularity. The I/O window ignores address bits 11:0 (4 KB). The memory, prefetchable and opaque windows ignore bits 19:0 (1 MB).
- R4: A window whose limit granule is below its base granule is off and contains no address.
- R5: All 64 address bits take part in the comparison, so addresses above 4 GB, as carried by dual address cycles, decode correctly.
- R6: When `opq_en`=1, a memory command whose address is inside the opaque window is not claimed on either side. With `opq_en`=0, the opaque window has no effect.
- R7: On the secondary side, configuration reads (code 4) and Type 0 configuration writes (code 5) are never claimed.
- R8: On the secondary side, a Type 1 configuration write (code 6) is claimed upstream only when `req_spc`=1. Configuration codes on the primary side are not claimed by this block. Reserved code 7 is never claimed on either side.
- R9: One clock after a request, `dec_valid` is 1 and `dec_addr` equals the received address with no translation.
- R10: After reset, `dec_valid`, `dec_claim`, `dec_dir` and `dec_addr` are 0. A cycle with `req_valid`=0 yields `dec_valid`=0 and `dec_claim`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_side | input | 1 | 0 = seen on primary, 1 = seen on secondary |
| req_cmd | input | 3 | Command code (see R1, R7, R8) |
| req_spc | input | 1 | Type 1 write asks for special-cycle conversion |
| req_addr | input | 64 | Full request address |
| io_base | input | 64 | I/O window base |
| io_limit | input | 64 | I/O window limit |
| mem_base | input | 64 | Memory window base |
| mem_limit | input | 64 | Memory window limit |
| pmem_base | input | 64 | Prefetchable window base |
| pmem_limit | input | 64 | Prefetchable window limit |
| opq_base | input | 64 | Opaque window base |
| opq_limit | input | 64 | Opaque window limit |
| opq_en | input | 1 | Opaque window switched on |
| dec_valid | output | 1 | Decision valid |
| dec_claim | output | 1 | Bridge claims the request |
| dec_dir | output | 1 | 0 = downstream, 1 = upstream (0 when not claimed) |
| dec_addr | output | 64 | Address to forward |

## Verification
Several properties are checked on every cycle: the forwarded address always equals the address received the cycle before; an idle cycle never produces a claim; a claim's direction always matches the side the request came from; a memory request that hits an enabled opaque window is never claimed; secondary configuration reads and Type 0 writes are never claimed; and a primary memory request with both memory windows switched off is never claimed. Only the bench scenarios can show the rest. These are the exact window edges at each granularity, the effect of the upper address bits above 4 GB, the inverse decode accepting addresses outside the windows, and the special-cycle gate on Type 1 writes. All of these need known window settings and chosen addresses.

// File: rtl/bdec_pkg.sv
package bdec_pkg;

  typedef enum logic [2:0] {
    CMD_IO_RD   = 3'd0,
    CMD_IO_WR   = 3'd1,
    CMD_MEM_RD  = 3'd2,
    CMD_MEM_WR  = 3'd3,
    CMD_CFG_RD  = 3'd4,
    CMD_CFG_WR0 = 3'd5,
    CMD_CFG_WR1 = 3'd6,
    CMD_RSVD    = 3'd7
  } bus_cmd_e;

  localparam int NUM_WIN  = 4;
  localparam int WIN_IO   = 0;
  localparam int WIN_MEM  = 1;
  localparam int WIN_PMEM = 2;
  localparam int WIN_OPQ  = 3;

  function automatic logic cmd_is_io(input bus_cmd_e c);
    return (c == CMD_IO_RD) || (c == CMD_IO_WR);
  endfunction

  function automatic logic cmd_is_mem(input bus_cmd_e c);
    return (c == CMD_MEM_RD) || (c == CMD_MEM_WR);
  endfunction

  function automatic int win_gran(input int idx, input int io_g, input int mem_g);
    return (idx == WIN_IO) ? io_g : mem_g;
  endfunction

endpackage

// File: rtl/bdec_window.sv
module bdec_window #(
  parameter int AW   = 64,
  parameter int GRAN = 20
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  output logic          win_on,
  output logic          hit
);
  localparam int GW = AW - GRAN;

  function automatic logic [GW-1:0] granule(input logic [AW-1:0] a);
    return a[AW-1:GRAN];
  endfunction

  function automatic logic inside_span(input logic [GW-1:0] g,
                                       input logic [GW-1:0] lo,
                                       input logic [GW-1:0] hi);
    return (g >= lo) && (g <= hi);
  endfunction

  logic [GW-1:0] a_g, b_g, l_g;

  always_comb begin
    a_g    = granule(addr);
    b_g    = granule(base);
    l_g    = granule(limit);
    win_on = (l_g >= b_g);
    hit    = win_on && inside_span(a_g, b_g, l_g);
  end

endmodule

// File: rtl/bdec_cfg_rules.sv
module bdec_cfg_rules
  import bdec_pkg::*;
(
  input  logic     side,
  input  bus_cmd_e cmd,
  input  logic     spc,
  output logic     cfg_claim
);
  logic spc_forward;

  always_comb begin
    spc_forward = side && (cmd == CMD_CFG_WR1) && spc;
    unique case (cmd)
      CMD_CFG_WR1: cfg_claim = spc_forward;
      default:     cfg_claim = 1'b0;
    endcase
  end

endmodule

// File: rtl/bridge_addr_decoder.sv
module bridge_addr_decoder
  import bdec_pkg::*;
#(
  parameter int AW       = 64,
  parameter int IO_GRAN  = 12,
  parameter int MEM_GRAN = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_side,
  input  logic [2:0]    req_cmd,
  input  logic          req_spc,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] io_base,
  input  logic [AW-1:0] io_limit,
  input  logic [AW-1:0] mem_base,
  input  logic [AW-1:0] mem_limit,
  input  logic [AW-1:0] pmem_base,
  input  logic [AW-1:0] pmem_limit,
  input  logic [AW-1:0] opq_base,
  input  logic [AW-1:0] opq_limit,
  input  logic          opq_en,
  output logic          dec_valid,
  output logic          dec_claim,
  output logic          dec_dir,
  output logic [AW-1:0] dec_addr
);

  bus_cmd_e cmd;
  assign cmd = bus_cmd_e'(req_cmd);

  logic [AW-1:0] w_base  [NUM_WIN];
  logic [AW-1:0] w_limit [NUM_WIN];
  logic [NUM_WIN-1:0] win_hit;
  logic [NUM_WIN-1:0] win_on;

  always_comb begin
    w_base[WIN_IO]    = io_base;    w_limit[WIN_IO]   = io_limit;
    w_base[WIN_MEM]   = mem_base;   w_limit[WIN_MEM]  = mem_limit;
    w_base[WIN_PMEM]  = pmem_base;  w_limit[WIN_PMEM] = pmem_limit;
    w_base[WIN_OPQ]   = opq_base;   w_limit[WIN_OPQ]  = opq_limit;
  end

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    bdec_window #(
      .AW  (AW),
      .GRAN(win_gran(i, IO_GRAN, MEM_GRAN))
    ) u_win (
      .addr  (req_addr),
      .base  (w_base[i]),
      .limit (w_limit[i]),
      .win_on(win_on[i]),
      .hit   (win_hit[i])
    );
  end

  logic cfg_claim;
  bdec_cfg_rules u_cfg (
    .side     (req_side),
    .cmd      (cmd),
    .spc      (req_spc),
    .cfg_claim(cfg_claim)
  );

  // Named internal events
  logic io_cmd, mem_cmd, sec_io_hit, sec_mem_hit, opq_block, claim_nxt;

  always_comb begin
    io_cmd      = cmd_is_io(cmd);
    mem_cmd     = cmd_is_mem(cmd);
    sec_io_hit  = win_hit[WIN_IO];
    sec_mem_hit = win_hit[WIN_MEM] | win_hit[WIN_PMEM];
    opq_block   = opq_en && win_hit[WIN_OPQ] && mem_cmd;
    if (io_cmd)
      claim_nxt = req_side ? !sec_io_hit : sec_io_hit;
    else if (mem_cmd)
      claim_nxt = !opq_block && (req_side ? !sec_mem_hit : sec_mem_hit);
    else
      claim_nxt = cfg_claim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_claim <= 1'b0;
      dec_dir   <= 1'b0;
      dec_addr  <= '0;
    end else begin
      dec_valid <= req_valid;
      dec_claim <= req_valid && claim_nxt;
      dec_dir   <= req_valid && claim_nxt && req_side;
      if (req_valid) dec_addr <= req_addr;
    end
  end

  // R9
  fwd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (dec_valid && dec_addr == $past(req_addr)));

  // R10
  idle_noclaim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!dec_valid && !dec_claim));

  // R2
  claim_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!dec_claim || dec_dir == $past(req_side)));

  // R6
  opaque_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && opq_en && win_hit[WIN_OPQ] && mem_cmd) |=> !dec_claim);

  // R7
  sec_cfg_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_side && (cmd == CMD_CFG_RD || cmd == CMD_CFG_WR0)) |=> !dec_claim);

  // R4
  off_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_side && mem_cmd && !win_on[WIN_MEM] && !win_on[WIN_PMEM])
      |=> !dec_claim);

endmodule

// File: tb/bridge_addr_decoder_test.sv
`timescale 1ns/1ps
module bridge_addr_decoder_test;

  typedef struct packed {
    logic        side;
    logic [2:0]  cmd;
    logic        spc;
    logic [63:0] addr;
    logic        claim;
    logic        dir;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd2, 1'b0, 64'h0000_0000_8000_0000, 1'b1, 1'b0}, // R1 R3 base edge
    '{1'b0, 3'd3, 1'b0, 64'h0000_0000_80FF_FFFF, 1'b1, 1'b0}, // R3 limit granule end
    '{1'b0, 3'd2, 1'b0, 64'h0000_0000_8100_0000, 1'b0, 1'b0}, // R3 past limit
    '{1'b0, 3'd2, 1'b0, 64'h0000_0000_7FFF_FFFF, 1'b0, 1'b0}, // R3 below base
    '{1'b0, 3'd3, 1'b0, 64'h0000_0001_0010_0ABC, 1'b1, 1'b0}, // R5 pmem high
    '{1'b0, 3'd2, 1'b0, 64'h0000_0000_0010_0000, 1'b0, 1'b0}, // R5 upper bits
    '{1'b0, 3'd0, 1'b0, 64'h0000_0000_0000_2000, 1'b1, 1'b0}, // R1 io base
    '{1'b0, 3'd1, 1'b0, 64'h0000_0000_0000_3FFF, 1'b1, 1'b0}, // R3 io granule end
    '{1'b0, 3'd0, 1'b0, 64'h0000_0000_0000_4000, 1'b0, 1'b0}, // R3 io past
    '{1'b0, 3'd0, 1'b0, 64'h0000_0000_8000_0000, 1'b0, 1'b0}, // R1 io cmd mem addr
    '{1'b1, 3'd2, 1'b0, 64'h0000_0000_8000_0000, 1'b0, 1'b0}, // R2 inside
    '{1'b1, 3'd3, 1'b0, 64'h0000_0000_9000_0000, 1'b1, 1'b1}, // R2 outside
    '{1'b1, 3'd2, 1'b0, 64'h0000_0001_0000_0010, 1'b0, 1'b0}, // R2 R5 pmem
    '{1'b1, 3'd2, 1'b0, 64'h0000_0002_0000_0000, 1'b1, 1'b1}, // R5 above
    '{1'b1, 3'd1, 1'b0, 64'h0000_0000_0000_2800, 1'b0, 1'b0}, // R2 io inside
    '{1'b1, 3'd0, 1'b0, 64'h0000_0000_0000_5000, 1'b1, 1'b1}, // R2 io outside
    '{1'b1, 3'd4, 1'b1, 64'h0000_0000_0000_0100, 1'b0, 1'b0}, // R7 cfg read
    '{1'b1, 3'd5, 1'b1, 64'h0000_0000_0000_0100, 1'b0, 1'b0}, // R7 type0 write
    '{1'b1, 3'd6, 1'b1, 64'h0000_0000_0000_0100, 1'b1, 1'b1}, // R8 special
    '{1'b1, 3'd6, 1'b0, 64'h0000_0000_0000_0100, 1'b0, 1'b0}, // R8 no special
    '{1'b0, 3'd6, 1'b1, 64'h0000_0000_0000_0100, 1'b0, 1'b0}, // R8 primary
    '{1'b1, 3'd7, 1'b1, 64'h0000_0000_9000_0000, 1'b0, 1'b0}  // R8 reserved
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_side = 1'b0, req_spc = 1'b0, opq_en = 1'b0;
  logic [2:0] req_cmd = '0;
  logic [63:0] req_addr = '0;
  logic [63:0] io_base, io_limit, mem_base, mem_limit;
  logic [63:0] pmem_base, pmem_limit, opq_base, opq_limit;
  logic dec_valid, dec_claim, dec_dir;
  logic [63:0] dec_addr;

  int n_cmp = 0, n_bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  bridge_addr_decoder uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_side(req_side),
    .req_cmd(req_cmd), .req_spc(req_spc), .req_addr(req_addr),
    .io_base(io_base), .io_limit(io_limit), .mem_base(mem_base),
    .mem_limit(mem_limit), .pmem_base(pmem_base), .pmem_limit(pmem_limit),
    .opq_base(opq_base), .opq_limit(opq_limit), .opq_en(opq_en),
    .dec_valid(dec_valid), .dec_claim(dec_claim), .dec_dir(dec_dir),
    .dec_addr(dec_addr)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at negedge, registered result sampled at the following negedge
  task automatic run(input string req, input logic side, input logic [2:0] cmd,
                     input logic spc, input logic [63:0] addr,
                     input logic exp_claim, input logic exp_dir);
    @(negedge clk);
    req_valid = 1'b1; req_side = side; req_cmd = cmd; req_spc = spc; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, "valid", {63'd0, dec_valid}, 64'd1);
    check(req, "claim", {63'd0, dec_claim}, {63'd0, exp_claim});
    check(req, "dir", {63'd0, dec_dir}, {63'd0, exp_claim & exp_dir});
    check("R9", "addr", dec_addr, addr);
  endtask

  task automatic set_default_windows();
    io_base   = 64'h2000;          io_limit   = 64'h3000;
    mem_base  = 64'h8000_0000;     mem_limit  = 64'h80F0_0000;
    pmem_base = 64'h1_0000_0000;   pmem_limit = 64'h1_0010_0000;
    opq_base  = 64'hC000_0000;     opq_limit  = 64'hC000_0000;
    opq_en    = 1'b0;
  endtask

  initial begin
    set_default_windows();
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "valid", {63'd0, dec_valid}, 64'd0);
    check("R10", "claim", {63'd0, dec_claim}, 64'd0);
    check("R10", "dir", {63'd0, dec_dir}, 64'd0);
    check("R10", "addr", dec_addr, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      run($sformatf("vec%0d", i), VEC[i].side, VEC[i].cmd, VEC[i].spc,
          VEC[i].addr, VEC[i].claim, VEC[i].dir);

    // R10 idle cycle after a claiming request
    run("R1", 1'b0, 3'd2, 1'b0, 64'h8000_0000, 1'b1, 1'b0);
    @(negedge clk);
    check("R10", "idle valid", {63'd0, dec_valid}, 64'd0);
    check("R10", "idle claim", {63'd0, dec_claim}, 64'd0);

    // R6 opaque window inside memory window, primary side
    opq_base = 64'h8040_0000; opq_limit = 64'h8040_0000; opq_en = 1'b1;
    run("R6", 1'b0, 3'd2, 1'b0, 64'h8040_0000, 1'b0, 1'b0);
    run("R6", 1'b0, 3'd3, 1'b0, 64'h804F_FFFF, 1'b0, 1'b0);
    run("R6", 1'b0, 3'd2, 1'b0, 64'h8050_0000, 1'b1, 1'b0);
    // R6 opaque window outside windows, secondary side
    opq_base = 64'hC000_0000; opq_limit = 64'hC000_0000;
    run("R6", 1'b1, 3'd2, 1'b0, 64'hC00F_FFFF, 1'b0, 1'b0);
    run("R6", 1'b1, 3'd3, 1'b0, 64'hC010_0000, 1'b1, 1'b1);
    run("R6", 1'b1, 3'd0, 1'b0, 64'hC000_0000, 1'b1, 1'b1);
    opq_en = 1'b0;
    run("R6", 1'b1, 3'd2, 1'b0, 64'hC000_0000, 1'b1, 1'b1);

    // R4 memory window switched off by limit below base
    mem_limit = 64'h7000_0000;
    run("R4", 1'b0, 3'd2, 1'b0, 64'h8000_0000, 1'b0, 1'b0);
    run("R4", 1'b1, 3'd2, 1'b0, 64'h8000_0000, 1'b1, 1'b1);
    // R4 I/O window off
    io_limit = 64'h1000;
    run("R4", 1'b0, 3'd0, 1'b0, 64'h2000, 1'b0, 1'b0);
    // R3 single-granule window (base equals limit)
    set_default_windows();
    mem_limit = 64'h8000_0000;
    run("R3", 1'b0, 3'd2, 1'b0, 64'h800F_FFFF, 1'b1, 1'b0);
    run("R3", 1'b0, 3'd2, 1'b0, 64'h8010_0000, 1'b0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule